// File: doc/BRIEF.md
# Debug Hart Selection and Run Control

This block sits inside a debug controller for a processor cluster of up to 32 harts. A debugger writes a control word naming one hart by index. It may also set an array-enable bit, which adds every hart flagged in a separate mask register. The same write carries halt and resume request bits, which are applied to every hart in that selected set. The block drives one level-held halt request line and one resume request pulse per hart. It records a per-hart resume-acknowledge flag, and folds the harts' halted and unavailable inputs into aggregate status flags and halt-summary words.

All state is reached through a byte-addressed register port. A write takes effect on the clock edge on which it is presented. Read data is combinational from the address and the current state. The control word sits at byte 0x00, status at 0x04, the hart mask at 0x08, the per-hart halt summary at 0x0C and the per-group halt summary at 0x10. An unaligned address or any other address reads as zero.

Top module: `hart_run_ctl`

## Requirements
- R1: After reset, haltreq_o, resumereq_o, every acknowledge flag, the mask, the stored index and the array-enable bit are zero.
- R2: The control word holds the halt bit at bit 0, the resume bit at bit 1, array-enable at bit 4 and the hart index at bits 20:16. A control write selects the indexed hart. When array-enable is 1 it also selects every hart whose mask bit is 1. The current mask is used, and the mask never replaces the indexed hart.
- R3: A control write sets haltreq_o of each selected hart to the written halt bit. It leaves unselected harts unchanged. haltreq_o holds its value until the next control write.
- R4: A control write with resume=1 and halt=0 drives resumereq_o high for exactly the cycle after the write, on the selected harts only.
- R5: A control write with both resume=1 and halt=1 issues no resume pulse to any hart.
- R6: A hart's acknowledge flag is set by hart_resack_i and cleared when a resume is issued to that hart; a clear wins over a set on the same edge. Status bit 8 is any-acknowledged and status bit 9 is all-acknowledged, both over the stored selection.
- R7: A stored index at or above NUM_HARTS is nonexistent and raises no request line. Status bit 6 (any-nonexistent) is 1 whenever the index is nonexistent. Status bit 7 (all-nonexistent) is 1 only if, in addition, no mask hart is selected.
- R8: An unavailable hart counts as neither halted nor running. Status bits 4 and 5 report any-unavailable and all-unavailable over the stored selection.
- R9: Status bits 0 through 3 are any-halted, all-halted, any-running and all-running over the stored selection. Every "all" flag is 0 when the selection is empty.
- R10: The word at 0x0C holds bit i set when hart i is halted and available. The word at 0x10 holds bit g set when any hart in group g of 32 is halted and available.
- R11: The mask keeps only NUM_HARTS bits, and unimplemented bits read as zero. The control word reads back only the index and the array-enable bit. Unaligned or unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| hart_halted_i | input | NUM_HARTS | Hart is halted |
| hart_unavail_i | input | NUM_HARTS | Hart is unavailable |
| hart_resack_i | input | NUM_HARTS | Hart has completed a resume |
| haltreq_o | output | NUM_HARTS | Level-held halt request per hart |
| resumereq_o | output | NUM_HARTS | One-cycle resume request per hart |

## Verification
The most difficult case to reach is a nonexistent index combined with array selection. Here all-nonexistent must fall while any-nonexistent stays high. The stimulus first loads a non-empty mask and then writes an out-of-range index with array-enable set. It repeats this with an empty mask to show that all-nonexistent returns. Dropping a resume that arrives with a halt is also hard to observe, because the halt bit itself changes haltreq_o. The bench therefore watches resumereq_o on every clock against a behavioural model, and it drives acknowledge pulses on the same edges as resume writes to test which of the two wins.

// File: rtl/hrc_pkg.sv
package hrc_pkg;
  localparam int unsigned SEL_W     = 5;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned GRP_SIZE  = 32;

  // word indices; byte offset = 4 * index
  localparam int WRD_CTRL  = 0;
  localparam int WRD_STAT  = 1;
  localparam int WRD_MASK  = 2;
  localparam int WRD_HSUM0 = 3;
  localparam int WRD_HSUM1 = 4;

  localparam int CTL_HALT   = 0;
  localparam int CTL_RESUME = 1;
  localparam int CTL_ARR    = 4;
  localparam int CTL_SEL_LO = 16;
  localparam int CTL_SEL_HI = CTL_SEL_LO + SEL_W - 1;

  // packed MSB first: halt_any lands at bit 0
  typedef struct packed {
    logic ack_all;
    logic ack_any;
    logic nonex_all;
    logic nonex_any;
    logic unav_all;
    logic unav_any;
    logic run_all;
    logic run_any;
    logic halt_all;
    logic halt_any;
  } stat_t;
endpackage

// File: rtl/hrc_decode.sv
module hrc_decode #(
  parameter int unsigned NUM_HARTS = 4
) (
  input  logic [hrc_pkg::SEL_W-1:0] idx_i,
  input  logic                      arr_en_i,
  input  logic [NUM_HARTS-1:0]      mask_i,
  output logic [NUM_HARTS-1:0]      sel_o,
  output logic                      idx_bad_o
);
  import hrc_pkg::*;

  always_comb begin
    idx_bad_o = (32'(idx_i) >= NUM_HARTS);
    sel_o     = arr_en_i ? mask_i : '0;
    for (int i = 0; i < int'(NUM_HARTS); i++) begin
      if (!idx_bad_o && idx_i == SEL_W'(i)) sel_o[i] = 1'b1;
    end
    // R7
    if (idx_bad_o && !arr_en_i) no_bad_idx_chk: assert (sel_o == '0);
  end
endmodule

// File: rtl/hrc_run.sv
module hrc_run #(
  parameter int unsigned NUM_HARTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 halt_bit_i,
  input  logic                 resume_bit_i,
  input  logic [NUM_HARTS-1:0] sel_i,
  input  logic [NUM_HARTS-1:0] resack_i,
  output logic [NUM_HARTS-1:0] haltreq_o,
  output logic [NUM_HARTS-1:0] resumereq_o,
  output logic [NUM_HARTS-1:0] ack_flag_o
);
  logic go;
  assign go = wr_i && resume_bit_i && !halt_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      haltreq_o   <= '0;
      resumereq_o <= '0;
      ack_flag_o  <= '0;
    end else begin
      resumereq_o <= go ? sel_i : '0;
      if (wr_i) haltreq_o <= (haltreq_o & ~sel_i) | (sel_i & {NUM_HARTS{halt_bit_i}});
      // issue clears, and beats a same-edge acknowledge
      ack_flag_o  <= go ? ((ack_flag_o | resack_i) & ~sel_i) : (ack_flag_o | resack_i);
    end
  end

  // R5
  no_resume_with_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|resumereq_o) |-> $past(wr_i && resume_bit_i && !halt_bit_i));
  // R3
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(haltreq_o));
  // R6
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|resumereq_o) |-> ((ack_flag_o & resumereq_o) == '0));
endmodule

// File: rtl/hrc_status.sv
module hrc_status #(
  parameter int unsigned NUM_HARTS = 4
) (
  input  logic [NUM_HARTS-1:0] sel_i,
  input  logic                 idx_bad_i,
  input  logic [NUM_HARTS-1:0] halted_i,
  input  logic [NUM_HARTS-1:0] unavail_i,
  input  logic [NUM_HARTS-1:0] ack_i,
  output hrc_pkg::stat_t       stat_o
);
  logic [NUM_HARTS-1:0] eff_halt, eff_run;
  logic                 has_sel;

  assign eff_halt = halted_i & ~unavail_i;
  assign eff_run  = ~halted_i & ~unavail_i;
  assign has_sel  = |sel_i;

  always_comb begin
    stat_o.halt_any  = |(sel_i & eff_halt);
    stat_o.halt_all  = has_sel && &(eff_halt | ~sel_i);
    stat_o.run_any   = |(sel_i & eff_run);
    stat_o.run_all   = has_sel && &(eff_run | ~sel_i);
    stat_o.unav_any  = |(sel_i & unavail_i);
    stat_o.unav_all  = has_sel && &(unavail_i | ~sel_i);
    stat_o.nonex_any = idx_bad_i;
    stat_o.nonex_all = idx_bad_i && !has_sel;
    stat_o.ack_any   = |(sel_i & ack_i);
    stat_o.ack_all   = has_sel && &(ack_i | ~sel_i);
  end
endmodule

// File: rtl/hart_run_ctl.sv
module hart_run_ctl #(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic [NUM_HARTS-1:0] hart_halted_i,
  input  logic [NUM_HARTS-1:0] hart_unavail_i,
  input  logic [NUM_HARTS-1:0] hart_resack_i,
  output logic [NUM_HARTS-1:0] haltreq_o,
  output logic [NUM_HARTS-1:0] resumereq_o
);
  import hrc_pkg::*;

  localparam int unsigned GROUPS = (NUM_HARTS + GRP_SIZE - 1) / GRP_SIZE;

  logic [SEL_W-1:0]     sel_q;
  logic                 arr_q;
  logic [NUM_HARTS-1:0] mask_q;
  logic [NUM_HARTS-1:0] wr_sel, cur_sel, ack_flag, eff_halt;
  logic                 wr_bad, cur_bad;
  logic [GROUPS-1:0]    hsum1;
  logic                 aligned, wr_ctrl, wr_mask;
  int                   word_idx;
  stat_t                stat;
  logic                 unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign aligned      = (reg_addr_i[1:0] == 2'b00);
  assign word_idx     = int'(reg_addr_i[ADDR_W-1:2]);
  assign wr_ctrl      = reg_we_i && aligned && word_idx == WRD_CTRL;
  assign wr_mask      = reg_we_i && aligned && word_idx == WRD_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      arr_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) begin
        sel_q <= reg_wdata_i[CTL_SEL_HI:CTL_SEL_LO];
        arr_q <= reg_wdata_i[CTL_ARR];
      end
      if (wr_mask) mask_q <= reg_wdata_i[NUM_HARTS-1:0];
    end
  end

  // selection applied by the incoming write
  hrc_decode #(.NUM_HARTS(NUM_HARTS)) u_dec_wr (
    .idx_i(reg_wdata_i[CTL_SEL_HI:CTL_SEL_LO]), .arr_en_i(reg_wdata_i[CTL_ARR]),
    .mask_i(mask_q), .sel_o(wr_sel), .idx_bad_o(wr_bad)
  );

  // selection reported in status
  hrc_decode #(.NUM_HARTS(NUM_HARTS)) u_dec_cur (
    .idx_i(sel_q), .arr_en_i(arr_q), .mask_i(mask_q),
    .sel_o(cur_sel), .idx_bad_o(cur_bad)
  );

  hrc_run #(.NUM_HARTS(NUM_HARTS)) u_run (
    .clk_i, .rst_ni, .wr_i(wr_ctrl),
    .halt_bit_i(reg_wdata_i[CTL_HALT]), .resume_bit_i(reg_wdata_i[CTL_RESUME]),
    .sel_i(wr_sel), .resack_i(hart_resack_i),
    .haltreq_o, .resumereq_o, .ack_flag_o(ack_flag)
  );

  hrc_status #(.NUM_HARTS(NUM_HARTS)) u_stat (
    .sel_i(cur_sel), .idx_bad_i(cur_bad), .halted_i(hart_halted_i),
    .unavail_i(hart_unavail_i), .ack_i(ack_flag), .stat_o(stat)
  );

  assign eff_halt = hart_halted_i & ~hart_unavail_i;

  for (genvar g = 0; g < int'(GROUPS); g++) begin : g_hsum
    localparam int LO = g * GRP_SIZE;
    localparam int HI = ((g + 1) * GRP_SIZE > NUM_HARTS) ? NUM_HARTS - 1 : LO + GRP_SIZE - 1;
    assign hsum1[g] = |eff_halt[HI:LO];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (aligned) begin
      case (word_idx)
        WRD_CTRL: begin
          reg_rdata_o[CTL_SEL_HI:CTL_SEL_LO] = sel_q;
          reg_rdata_o[CTL_ARR]               = arr_q;
        end
        WRD_STAT:  reg_rdata_o[$bits(stat_t)-1:0] = stat;
        WRD_MASK:  reg_rdata_o[NUM_HARTS-1:0]     = mask_q;
        WRD_HSUM0: reg_rdata_o[NUM_HARTS-1:0]     = eff_halt;
        WRD_HSUM1: reg_rdata_o[GROUPS-1:0]        = hsum1;
        default:   reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: tb/tb_hart_run_ctl.sv
module tb_hart_run_ctl;
  localparam int  N          = 4;
  localparam time CLK_PERIOD = 10;

  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic         we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0, rdata;
  logic [N-1:0] halted = '0, unavail = '0, resack = '0;
  logic [N-1:0] haltreq, resumereq;

  int checks = 0, errors = 0;

  hart_run_ctl #(.NUM_HARTS(N), .ADDR_W(8)) dut (
    .clk_i, .rst_ni, .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .hart_halted_i(halted), .hart_unavail_i(unavail),
    .hart_resack_i(resack), .haltreq_o(haltreq), .resumereq_o(resumereq)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // behavioural model
  bit [N-1:0] m_halt, m_res, m_ack, m_mask;
  int         m_idx;
  bit         m_arr;

  function automatic bit [N-1:0] pick(int idx, bit arr, bit [N-1:0] mask);
    bit [N-1:0] r = arr ? mask : '0;
    if (idx < N) r[idx] = 1'b1;
    return r;
  endfunction

  always @(posedge clk_i) begin
    bit [N-1:0] s;
    bit [N-1:0] nres;
    nres = '0;
    if (!rst_ni) begin
      m_halt = '0; m_res = '0; m_ack = '0; m_mask = '0; m_idx = 0; m_arr = 1'b0;
    end else begin
      m_ack = m_ack | resack;
      if (we && addr == 8'h00) begin
        s = pick(int'(wdata[20:16]), wdata[4], m_mask);
        for (int i = 0; i < N; i++) if (s[i]) m_halt[i] = wdata[0];
        if (wdata[1] && !wdata[0]) begin
          nres  = s;
          m_ack = m_ack & ~s;
        end
        m_idx = int'(wdata[20:16]);
        m_arr = wdata[4];
      end
      if (we && addr == 8'h08) m_mask = wdata[N-1:0];
      m_res = nres;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(haltreq == m_halt, "R2/R3 haltreq", 32'(haltreq), 32'(m_halt));
      chk(resumereq == m_res, "R4/R5 resumereq", 32'(resumereq), 32'(m_res));
    end
  end

  function automatic bit [31:0] exp_status();
    bit [N-1:0] s, eh, er;
    bit [31:0]  st;
    bit         has;
    s   = pick(m_idx, m_arr, m_mask);
    eh  = halted & ~unavail;
    er  = ~halted & ~unavail;
    has = (s != 0);
    st  = '0;
    st[0] = |(s & eh);
    st[1] = has && ((s & eh) == s);
    st[2] = |(s & er);
    st[3] = has && ((s & er) == s);
    st[4] = |(s & unavail);
    st[5] = has && ((s & unavail) == s);
    st[6] = (m_idx >= N);
    st[7] = (m_idx >= N) && !has;
    st[8] = |(s & m_ack);
    st[9] = has && ((s & m_ack) == s);
    return st;
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk_i);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] ctl(bit halt, bit res, bit arr, int idx);
    return (32'(idx) << 16) | (32'(arr) << 4) | (32'(res) << 1) | 32'(halt);
  endfunction

  task automatic check_all();
    logic [31:0] d, e;
    bit   [N-1:0] eh;
    eh = halted & ~unavail;
    rd(8'h04, d);
    e = exp_status();
    chk(d[3:0] == e[3:0], "R9 halted/running", d, e);
    chk(d[5:4] == e[5:4], "R8 unavailable", d, e);
    chk(d[7:6] == e[7:6], "R7 nonexistent", d, e);
    chk(d[9:8] == e[9:8], "R6 resumeack", d, e);
    chk(d[31:10] == 0, "R11 status upper", d, e);
    rd(8'h0C, d);
    chk(d == 32'(eh), "R10 haltsum0", d, 32'(eh));
    rd(8'h10, d);
    chk(d == {31'b0, |eh}, "R10 haltsum1", d, {31'b0, |eh});
    rd(8'h08, d);
    chk(d == 32'(m_mask), "R11 mask readback", d, 32'(m_mask));
    rd(8'h00, d);
    e = ctl(1'b0, 1'b0, m_arr, m_idx);
    chk(d == e, "R11 ctrl readback", d, e);
  endtask

  task automatic ack(bit [N-1:0] v);
    @(negedge clk_i);
    resack = v;
    @(negedge clk_i);
    resack = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] lfsr = 32'hACE1_2468;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(haltreq == 0 && resumereq == 0, "R1 outputs", 32'({haltreq, resumereq}), 0);
    rd(8'h00, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(8'h08, d); chk(d == 0, "R1 mask", d, 0);
    check_all();

    // single hart halt
    wr(8'h00, ctl(1, 0, 0, 1));
    chk(haltreq == 4'b0010, "R3 single halt", 32'(haltreq), 32'h2);
    halted = 4'b0010;
    check_all();

    // R11 mask truncation then real mask
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); chk(d == 32'hF, "R11 mask width", d, 32'hF);
    wr(8'h08, 32'h0000_000C);

    // R2 array selection adds the indexed hart
    wr(8'h00, ctl(1, 0, 1, 0));
    chk(haltreq == 4'b1111, "R2 mask plus index", 32'(haltreq), 32'hF);
    halted = 4'b1111;
    check_all();

    // R5 resume with halt dropped
    wr(8'h00, ctl(1, 1, 1, 1));
    chk(resumereq == 0, "R5 no resume", 32'(resumereq), 0);

    // R3 clear on {1,2,3}, R4 pulse
    wr(8'h00, ctl(0, 0, 1, 1));
    chk(haltreq == 4'b0001, "R3 clear selected", 32'(haltreq), 32'h1);
    ack(4'b1111);
    check_all();
    @(negedge clk_i);
    we = 1'b1; addr = 8'h00; wdata = ctl(0, 1, 1, 1); resack = 4'b0110;
    @(negedge clk_i);
    we = 1'b0; resack = '0;
    chk(resumereq == 4'b1110, "R4 pulse", 32'(resumereq), 32'hE);
    @(negedge clk_i);
    chk(resumereq == 0, "R4 single cycle", 32'(resumereq), 0);
    halted = 4'b0001;
    check_all();
    ack(4'b0100);
    check_all();
    ack(4'b1010);
    check_all();

    // R7 nonexistent index
    wr(8'h00, ctl(1, 1, 0, 7));
    chk(haltreq == 4'b0001, "R7 no request", 32'(haltreq), 32'h1);
    check_all();
    wr(8'h00, ctl(0, 0, 1, 7));
    check_all();
    wr(8'h08, 32'h0);
    check_all();

    // R8 unavailable excluded
    wr(8'h08, 32'h0000_0008);
    wr(8'h00, ctl(0, 0, 1, 2));
    halted = 4'b1100; unavail = 4'b1000;
    check_all();
    unavail = 4'b1100;
    check_all();

    // R11 unmapped and unaligned
    rd(8'h40, d); chk(d == 0, "R11 unmapped", d, 0);
    rd(8'h05, d); chk(d == 0, "R11 unaligned", d, 0);

    // mixed stimulus
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      halted  = lfsr[11:8];
      unavail = lfsr[15:12] & lfsr[27:24];
      case (lfsr[3:2])
        2'd0: wr(8'h08, {28'b0, lfsr[19:16]});
        2'd3: ack(lfsr[23:20]);
        default: begin
          @(negedge clk_i);
          we = 1'b1; addr = 8'h00; resack = lfsr[23:20];
          wdata = ctl(lfsr[4], lfsr[5], lfsr[6], int'(lfsr[30:28]));
          @(negedge clk_i);
          we = 1'b0; resack = '0;
        end
      endcase
      if (lfsr[7]) check_all();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule